// File: doc/BRIEF.md
# Timer-Triggered Dual Serial Converter Sampler

This block reads two external analog-to-digital converters at a fixed rate, with no software involved once it runs. A free-running sample timer counts from zero up to a programmable period and then wraps. Each of the two channels has its own compare value. When the timer reaches that value, the channel pulls its active-low convert/select line low. It waits a programmable setup interval so the converter can finish its conversion. It then clocks sixteen bits in from the converter's serial data output, most significant bit first. The links only receive: no data is ever sent to the converters.

Each finished read appears as a 16-bit two's-complement code with a one-cycle valid strobe. A channel has to be re-armed before it can start another read. Re-arming happens at timer rollover, or at any time while the timer is stopped. A compare that lands while the channel is idle but not re-armed is dropped without any flag. A compare that lands while a read is still running sets a sticky missed flag.

The compare values should differ by one count, for example 2 and 3. The two reads then never start on the same clock.

Top module: `adc_pair_sampler`

## Requirements
- R1: After reset both select lines are high, both serial clocks are low, both valid strobes and missed flags are low, and both data words are zero.
- R2: The timer counts 0..period and wraps to 0. While the enable input is low the timer is held at 0 and no read starts. While it is high, a channel's select line falls on the clock edge that ends the cycle in which the timer equals that channel's compare value. With the timer enabled and every read allowed, consecutive starts on a channel are period+1 cycles apart.
- R3: With the channel 1 compare value one above channel 0's, channel 1's select line falls exactly one cycle after channel 0's.
- R4: The first rising serial clock edge comes exactly setup_cycles + SCK_HALF system cycles after the select line falls, and the serial clock stays low until then. A setup_cycles value of 0 counts as 1.
- R5: The serial clock is high for SCK_HALF cycles and low for SCK_HALF cycles, and is high only while the select line is low. There are exactly 16 rising edges per read, and the data input is sampled at each rising edge.
- R6: The first bit sampled is bit 15 of the output word. The word is the converter's two's-complement code, passed on unchanged.
- R7: The valid strobe lasts exactly one cycle and appears in the cycle after the 16th bit is sampled. Every read produces one strobe.
- R8: The select line rises exactly 2*SCK_HALF cycles after the 16th sampling edge, and is still low in the cycle after the strobe.
- R9: A channel is armed at timer wrap and while the timer is disabled, and it is disarmed when a read ends. If both happen on the same edge, arming wins. A compare that finds the channel idle but disarmed starts nothing and does not set the missed flag.
- R10: A compare that arrives during a read sets that channel's missed flag. The flag stays set until reset, and the running read is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Sample timer enable |
| period | input | CNT_W | Highest timer count before wrap |
| cmp0 | input | CNT_W | Channel 0 trigger count |
| cmp1 | input | CNT_W | Channel 1 trigger count |
| setup_cycles | input | SETUP_W | Conversion setup interval in system cycles |
| miso0 | input | 1 | Channel 0 serial data from converter |
| miso1 | input | 1 | Channel 1 serial data from converter |
| csn0 | output | 1 | Channel 0 convert/select, active low |
| csn1 | output | 1 | Channel 1 convert/select, active low |
| sck0 | output | 1 | Channel 0 serial clock |
| sck1 | output | 1 | Channel 1 serial clock |
| data0 | output | NBITS | Channel 0 sample code |
| data1 | output | NBITS | Channel 1 sample code |
| valid0 | output | 1 | Channel 0 sample strobe |
| valid1 | output | 1 | Channel 1 sample strobe |
| missed0 | output | 1 | Channel 0 sticky missed-trigger flag |
| missed1 | output | 1 | Channel 1 sticky missed-trigger flag |

## Verification
The assertions watch the framing rules on every cycle for both channels:
- The serial clock is high only while the select line is low.
- The serial clock is still low in the cycle after the select line falls.
- A read starts only if the timer was enabled.
- Strobes last one cycle, and the select line is still low after a strobe.
- Missed flags never clear.

Some behaviours only the bench scenarios can show: the exact setup gap, the spacing between starts, the one-cycle offset between channels, the bit order and signed value of the codes, and the release delay. The same holds for the re-arm rule, which the bench exposes with a period whose rollover falls inside a read, so that every second compare is dropped without a flag.

// File: rtl/adc_pair_sampler.sv
module adc_pair_sampler #(
  parameter int CNT_W    = 16,
  parameter int SETUP_W  = 8,
  parameter int SCK_HALF = 2,
  parameter int NBITS    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_en,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   cmp0,
  input  logic [CNT_W-1:0]   cmp1,
  input  logic [SETUP_W-1:0] setup_cycles,
  input  logic               miso0,
  input  logic               miso1,
  output logic               csn0,
  output logic               csn1,
  output logic               sck0,
  output logic               sck1,
  output logic [NBITS-1:0]   data0,
  output logic [NBITS-1:0]   data1,
  output logic               valid0,
  output logic               valid1,
  output logic               missed0,
  output logic               missed1
);
  localparam int PH_W = $clog2(2 * SCK_HALF + 1);
  localparam int BC_W = $clog2(NBITS + 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCK_HALF - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * SCK_HALF - 1);

  typedef enum logic [1:0] {IDLE, SETUP, SHIFT, HOLD} st_t;

  logic [CNT_W-1:0] tcnt;
  wire wrap = tmr_en && (tcnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n)                tcnt <= '0;
    else if (!tmr_en || wrap)  tcnt <= '0;
    else                       tcnt <= tcnt + 1'b1;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    wire [CNT_W-1:0] cmp_w  = (ch == 0) ? cmp0 : cmp1;
    wire             miso_w = (ch == 0) ? miso0 : miso1;
    wire             trig   = tmr_en && (tcnt == cmp_w);

    st_t              st;
    logic [SETUP_W-1:0] scnt;
    logic [PH_W-1:0]  ph;
    logic [BC_W-1:0]  bcnt;
    logic [NBITS-2:0] sh;
    logic             csn_r, sck_r, valid_r, armed, missed_r;
    logic [NBITS-1:0] data_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st       <= IDLE;
        scnt     <= '0;
        ph       <= '0;
        bcnt     <= '0;
        sh       <= '0;
        csn_r    <= 1'b1;
        sck_r    <= 1'b0;
        valid_r  <= 1'b0;
        armed    <= 1'b1;
        missed_r <= 1'b0;
        data_r   <= '0;
      end else begin
        valid_r <= 1'b0;
        if (trig && st != IDLE) missed_r <= 1'b1;
        if (wrap || !tmr_en)                 armed <= 1'b1;
        else if (st == HOLD && ph == PH_RISE) armed <= 1'b0;
        unique case (st)
          IDLE: if (trig && armed) begin
            st    <= SETUP;
            csn_r <= 1'b0;
            scnt  <= '0;
          end
          SETUP: begin
            if ({1'b0, scnt} + 1'b1 >= {1'b0, setup_cycles}) begin
              st   <= SHIFT;
              ph   <= '0;
              bcnt <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          SHIFT: begin
            if (ph == PH_LAST) begin
              ph    <= '0;
              sck_r <= 1'b0;
              if (bcnt == BC_W'(NBITS)) st <= HOLD;
            end else begin
              ph <= ph + 1'b1;
            end
            if (ph == PH_RISE) begin
              sck_r <= 1'b1;
              sh    <= {sh[NBITS-3:0], miso_w};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == BC_W'(NBITS - 1)) begin
                data_r  <= {sh, miso_w};
                valid_r <= 1'b1;
              end
            end
          end
          HOLD: begin
            if (ph == PH_RISE) begin
              csn_r <= 1'b1;
              st    <= IDLE;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign csn0    = g_ch[0].csn_r;
  assign csn1    = g_ch[1].csn_r;
  assign sck0    = g_ch[0].sck_r;
  assign sck1    = g_ch[1].sck_r;
  assign data0   = g_ch[0].data_r;
  assign data1   = g_ch[1].data_r;
  assign valid0  = g_ch[0].valid_r;
  assign valid1  = g_ch[1].valid_r;
  assign missed0 = g_ch[0].missed_r;
  assign missed1 = g_ch[1].missed_r;
endmodule

// File: rtl/adc_pair_sampler_chk.sv
module adc_pair_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic tmr_en,
  input logic csn0,
  input logic csn1,
  input logic sck0,
  input logic sck1,
  input logic valid0,
  input logic valid1,
  input logic missed0,
  input logic missed1
);
  assert_start_enabled0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn0) |-> $past(tmr_en));
  assert_start_enabled1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn1) |-> $past(tmr_en));
  assert_setup_quiet0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn0) |=> !sck0);
  assert_setup_quiet1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn1) |=> !sck1);
  assert_sck_framed0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck0 |-> !csn0);
  assert_sck_framed1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck1 |-> !csn1);
  assert_valid_single0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid0 |=> !valid0);
  assert_valid_single1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid1 |=> !valid1);
  assert_hold_after_valid0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid0 |=> !csn0);
  assert_hold_after_valid1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid1 |=> !csn1);
  assert_missed_sticky0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    missed0 |=> missed0);
  assert_missed_sticky1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    missed1 |=> missed1);
endmodule

bind adc_pair_sampler adc_pair_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en),
  .csn0(csn0), .csn1(csn1), .sck0(sck0), .sck1(sck1),
  .valid0(valid0), .valid1(valid1), .missed0(missed0), .missed1(missed1)
);

// File: tb/adc_pair_sampler_test.sv
module adc_pair_sampler_test;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0;
  logic [15:0] period = 16'd100;
  logic [15:0] cmp0 = 16'd2;
  logic [15:0] cmp1 = 16'd3;
  logic [7:0]  setup_cycles = 8'd4;
  logic        miso0 = 1'b0, miso1 = 1'b0;
  logic        csn0, csn1, sck0, sck1, valid0, valid1, missed0, missed1;
  logic [15:0] data0, data1;

  always #10 clk = ~clk;

  adc_pair_sampler #(.CNT_W(16), .SETUP_W(8), .SCK_HALF(H), .NBITS(16)) uut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .period(period),
    .cmp0(cmp0), .cmp1(cmp1), .setup_cycles(setup_cycles),
    .miso0(miso0), .miso1(miso1), .csn0(csn0), .csn1(csn1),
    .sck0(sck0), .sck1(sck1), .data0(data0), .data1(data1),
    .valid0(valid0), .valid1(valid1), .missed0(missed0), .missed1(missed1)
  );

  int nchecks = 0, nerr = 0;
  int exp_interval = 0;
  int falls = 0;
  logic [15:0] q0[$], q1[$];

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] code_of(int c, int k);
    case ((k % 4) + 4 * c)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0001;
      3: return 16'hA5C3;
      4: return 16'hFFFF;
      5: return 16'h0000;
      6: return 16'h5A3C;
      default: return 16'h1234;
    endcase
  endfunction

  // converter models: present bit 15 on select fall, next bit on each falling clock
  initial begin
    int k = 0;
    forever begin
      logic [15:0] w;
      @(negedge csn0);
      w = code_of(0, k); k++;
      q0.push_back(w);
      miso0 = w[15];
      for (int i = 14; i >= 0; i--) begin
        @(negedge sck0);
        miso0 = w[i];
      end
    end
  end

  initial begin
    int k = 0;
    forever begin
      logic [15:0] w;
      @(negedge csn1);
      w = code_of(1, k); k++;
      q1.push_back(w);
      miso1 = w[15];
      for (int i = 14; i >= 0; i--) begin
        @(negedge sck1);
        miso1 = w[i];
      end
    end
  end

  // monitor / scoreboard
  initial begin
    int cyc = 0;
    int last_fall[2] = '{-1, -1};
    int fall_cyc[2] = '{0, 0};
    int nrise[2] = '{0, 0};
    int vcyc[2] = '{0, 0};
    logic pc[2] = '{1'b1, 1'b1};
    logic ps[2] = '{1'b0, 1'b0};
    logic pv[2] = '{1'b0, 1'b0};
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        for (int c = 0; c < 2; c++) begin
          logic cs, sk, vl;
          logic [15:0] d;
          cs = (c == 0) ? csn0 : csn1;
          sk = (c == 0) ? sck0 : sck1;
          vl = (c == 0) ? valid0 : valid1;
          d  = (c == 0) ? data0 : data1;
          if (!tmr_en) last_fall[c] = -1;
          if (pc[c] && !cs) begin
            falls++;
            fall_cyc[c] = cyc;
            nrise[c] = 0;
            if (c == 1) chk(fall_cyc[1] - fall_cyc[0] == 1, "R3 channel offset",
                            fall_cyc[1] - fall_cyc[0], 1);
            if (last_fall[c] >= 0 && exp_interval != 0)
              chk(cyc - last_fall[c] == exp_interval, "R2/R9 start spacing",
                  cyc - last_fall[c], exp_interval);
            if (tmr_en) last_fall[c] = cyc;
          end
          if (!ps[c] && sk) begin
            int s;
            nrise[c]++;
            s = (setup_cycles == 0) ? 1 : int'(setup_cycles);
            if (nrise[c] == 1)
              chk(cyc - fall_cyc[c] == s + H, "R4 setup gap", cyc - fall_cyc[c], s + H);
          end
          if (vl) begin
            logic [15:0] e;
            int ei;
            chk(!pv[c], "R7 strobe width", 2, 1);
            chk((c == 0 ? q0.size() : q1.size()) > 0, "R7 strobe without read",
                0, 1);
            if ((c == 0 ? q0.size() : q1.size()) > 0) begin
              e = (c == 0) ? q0.pop_front() : q1.pop_front();
              chk(d == e, "R5/R6 sample code", d, e);
              ei = e[15] ? int'(e) - 65536 : int'(e);
              chk(int'($signed(d)) == ei, "R6 signed value", int'($signed(d)), ei);
            end
            vcyc[c] = cyc;
            chk(nrise[c] == 16, "R7 strobe after 16th bit", nrise[c], 16);
          end
          if (!pc[c] && cs) begin
            chk(nrise[c] == 16, "R5 clock count", nrise[c], 16);
            chk(cyc - vcyc[c] == 2 * H, "R8 release delay", cyc - vcyc[c], 2 * H);
          end
          pc[c] = cs; ps[c] = sk; pv[c] = vl;
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finish_up();
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(csn0 && csn1, "R1 select high", {csn1, csn0}, 3);
    chk(!sck0 && !sck1, "R1 clock low", {sck1, sck0}, 0);
    chk(!valid0 && !valid1, "R1 strobe low", {valid1, valid0}, 0);
    chk(!missed0 && !missed1, "R1 missed low", {missed1, missed0}, 0);
    chk(data0 == 0 && data1 == 0, "R1 data zero", data0 | data1, 0);
    // R2 timer disabled: nothing starts
    step(300);
    chk(falls == 0, "R2 disabled timer", falls, 0);
    // R2 normal periodic sampling
    exp_interval = 101;
    tmr_en = 1'b1;
    step(5 * 101);
    tmr_en = 1'b0;
    step(150);
    // R4 longer setup
    setup_cycles = 8'd9;
    tmr_en = 1'b1;
    step(5 * 101);
    tmr_en = 1'b0;
    step(150);
    // R4 zero setup counts as one
    setup_cycles = 8'd0;
    tmr_en = 1'b1;
    step(3 * 101);
    tmr_en = 1'b0;
    step(150);
    // R9 rollover inside the read: every other compare dropped, no flag
    setup_cycles = 8'd4;
    period = 16'd70;
    exp_interval = 142;
    tmr_en = 1'b1;
    step(5 * 142);
    tmr_en = 1'b0;
    step(150);
    chk(!missed0 && !missed1, "R9 dropped compare sets no flag", {missed1, missed0}, 0);
    // R10 compare during a read
    period = 16'd40;
    exp_interval = 0;
    tmr_en = 1'b1;
    step(300);
    tmr_en = 1'b0;
    step(150);
    chk(missed0 && missed1, "R10 missed flag set", {missed1, missed0}, 3);
    step(50);
    chk(missed0 && missed1, "R10 missed flag sticky", {missed1, missed0}, 3);
    chk(q0.size() == 0 && q1.size() == 0, "R7 every read strobed",
        q0.size() + q1.size(), 0);
    finish_up();
  end
endmodule